// File: doc/BRIEF.md
# Buffered Serial Port with Sticky Overrun Flags

This block is a register-mapped asynchronous serial port for an on-chip peripheral bus. Each direction has a single byte of buffering. Software writes a byte into the transmit holding slot. The transmitter then sends it as one start bit, eight data bits (least significant first) and one stop bit. The receiver watches the incoming line, recovers each frame and parks the byte in a receive holding slot until software reads it. A programmable divider sets the bit length in clock cycles. Each direction has its own enable. Four interrupt sources drive two interrupt outputs, one per direction.

When software writes into a full transmit slot, the byte is lost and a transmit overrun flag is set. When a frame arrives while the receive slot is still full, the new byte is lost and a receive overrun flag is set. Both flags stay set until software writes a one to them. A test mode sends transmit data at one bit per clock, whatever the divider holds.

Both serial engines are small four-state machines with the states LN_IDLE, LN_START, LN_DATA and LN_STOP. The transmitter moves through them as follows:
- LN_IDLE to LN_START on a load from the holding slot.
- LN_START to LN_DATA when the bit time has elapsed.
- LN_DATA to LN_STOP after the eighth bit time.
- LN_STOP to LN_IDLE when the bit time has elapsed.

The receiver moves through the same states as follows:
- LN_IDLE to LN_START on a synchronized falling edge while it is armed.
- LN_START to LN_DATA when the line is still low at half a bit time. It returns to LN_IDLE instead if the line is high there, which is a false start.
- LN_DATA to LN_STOP after eight samples, each one bit time apart.
- LN_STOP to LN_IDLE after the stop sample. The byte is delivered only if that sample is high.

Top module: `sbuf_uart`

## Requirements
- R1: After reset, every register reads zero, `ser_tx` is high and both interrupt outputs are low.
- R2: The register word offsets are decoded on `bus_waddr` as follows:
  - 0: data. A write fills the transmit slot; a read returns the received byte.
  - 1: status. Bit 0 is transmit full, bit 1 is receive full, bit 2 is transmit overrun and bit 3 is receive overrun.
  - 2: control. Bit 0 enables transmit, bit 1 enables receive, bit 2 enables the transmit interrupt, bit 3 enables the receive interrupt, bit 4 enables the transmit-overrun interrupt, bit 5 enables the receive-overrun interrupt, and bit 6 selects the fast test mode.
  - 3: interrupt status. Bit 0 is transmit, bit 1 is receive, bit 2 is transmit overrun and bit 3 is receive overrun.
  - 4: divider.

  Control and divider read back as written.
- R3: With transmit enabled, a full slot is loaded into the shifter one cycle after it fills, if the shifter is idle. The line then carries a low start bit, the eight data bits least significant first, and a high stop bit, each lasting `divider` cycles. The slot reads empty from the load on.
- R4: A divider below 16 starts no transfer in either direction: the line stays high and the transmit slot stays full.
- R5: In fast test mode every transmit bit lasts one cycle, whatever the divider holds.
- R6: A data write while the transmit slot is full discards the byte and sets status bit 2. Status bit 2 stays set until a write of 1 to status bit 2.
- R7: With receive enabled, the receiver samples each bit at mid-bit after a synchronized start edge. The received byte lands in the slot and sets status bit 1. A bus read of the data word clears status bit 1. With receive disabled, nothing is received.
- R8: A frame that completes while the receive slot is full is discarded: the slot keeps the old byte. The frame sets status bit 3, which stays set until a write of 1 to status bit 3.
- R9: Each interrupt status bit is set by its event only when its enable is set, and is cleared by writing 1 to the same bit. `irq_tx` is bit 0 OR bit 2, and `irq_rx` is bit 1 OR bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_waddr` |
| ser_rx | input | 1 | Serial input, asynchronous |
| ser_tx | output | 1 | Serial output, idle high |
| irq_tx | output | 1 | Transmit-side interrupt |
| irq_rx | output | 1 | Receive-side interrupt |

## Verification
The bench compares the serial line against a frame model on every clock. This catches a design that shifts most-significant-bit first, miscounts bit lengths, or loads late. Each byte is sent with a different bit pattern. Further cases drive these situations:
- A divider below the threshold, where a faulty design would emit garbage frames.
- The fast test mode, where a faulty design would still apply the divider.
- Writes into a full transmit slot, where a faulty design would overwrite the pending byte or fail to latch the overrun flag.
- Back-to-back frames into an unread receive slot, where a faulty design would replace the held byte.
- Reception with the receiver disabled.

Interrupt status is checked against each enable, and each write-one clear is checked as well. A design that raises interrupts without its enable, or clears the wrong bit, is reported.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
    typedef enum logic [1:0] {LN_IDLE, LN_START, LN_DATA, LN_STOP} line_st_e;
    localparam int MIN_DIV = 16;
    localparam int NBITS   = 8;
endpackage

// File: rtl/sbu_tx.sv
module sbu_tx
    import sbu_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       din,
    input  logic [DIV_W-1:0] bit_len,
    output logic             ready,
    output logic             txd
);
    localparam int IDX_W = $clog2(NBITS);

    line_st_e         state_q, state_d;
    logic [DIV_W-1:0] cnt_q, len_q;
    logic [7:0]       sh_q;
    logic [IDX_W-1:0] idx_q;
    logic             bit_end;

    assign bit_end = (cnt_q == len_q - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE:  if (load) state_d = LN_START;
            LN_START: if (bit_end) state_d = LN_DATA;
            LN_DATA:  if (bit_end && idx_q == IDX_W'(NBITS - 1)) state_d = LN_STOP;
            LN_STOP:  if (bit_end) state_d = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= DIV_W'(1);
            sh_q  <= '0;
            idx_q <= '0;
        end else if (state_q == LN_IDLE) begin
            if (load) begin
                len_q <= bit_len;
                sh_q  <= din;
                cnt_q <= '0;
                idx_q <= '0;
            end
        end else if (bit_end) begin
            cnt_q <= '0;
            if (state_q == LN_DATA) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        ready = (state_q == LN_IDLE);
        unique case (state_q)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = sh_q[0];
            default:  txd = 1'b1;
        endcase
    end

    // R3: the holding logic only loads an idle shifter
    a_r3_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> state_q == LN_IDLE);
    // R3: a started frame always runs through its data bits
    a_r3_start_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_START && bit_end) |=> state_q == LN_DATA);
endmodule

// File: rtl/sbu_rx.sv
module sbu_rx
    import sbu_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             rxd,
    input  logic [DIV_W-1:0] bit_len,
    output logic             got,
    output logic [7:0]       dout
);
    localparam int IDX_W = $clog2(NBITS);

    line_st_e         state_q, state_d;
    logic [2:0]       sync_q;
    logic [DIV_W-1:0] cnt_q, len_q;
    logic [7:0]       sh_q;
    logic [IDX_W-1:0] idx_q;
    logic             bit_end, mid_pt, fall, line;

    assign line    = sync_q[1];
    assign fall    = sync_q[2] & ~sync_q[1];
    assign bit_end = (cnt_q == len_q - 1'b1);
    assign mid_pt  = (cnt_q == (len_q >> 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE:  if (arm && fall) state_d = LN_START;
            LN_START: if (mid_pt) state_d = line ? LN_IDLE : LN_DATA;
            LN_DATA:  if (bit_end && idx_q == IDX_W'(NBITS - 1)) state_d = LN_STOP;
            LN_STOP:  if (bit_end) state_d = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 3'b111;
            cnt_q  <= '0;
            len_q  <= DIV_W'(MIN_DIV);
            sh_q   <= '0;
            idx_q  <= '0;
            got    <= 1'b0;
            dout   <= '0;
        end else begin
            sync_q <= {sync_q[1:0], rxd};
            got    <= 1'b0;
            unique case (state_q)
                LN_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                    len_q <= bit_len;
                end
                LN_START: cnt_q <= mid_pt ? '0 : cnt_q + 1'b1;
                LN_DATA: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        sh_q  <= {line, sh_q[7:1]};
                        idx_q <= idx_q + 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                LN_STOP: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        got   <= line;
                        dout  <= line ? sh_q : dout;
                    end else cnt_q <= cnt_q + 1'b1;
                end
            endcase
        end
    end

    // R4, R7: an unarmed receiver never leaves idle
    a_r7_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_IDLE && !arm) |=> state_q == LN_IDLE);
    // R7: a byte is only delivered out of the stop state
    a_r7_got_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        got |-> $past(state_q) == LN_STOP);
endmodule

// File: rtl/sbuf_uart.sv
module sbuf_uart
    import sbu_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [2:0]       bus_waddr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ser_rx,
    output logic             ser_tx,
    output logic             irq_tx,
    output logic             irq_rx
);
    localparam int DIV_W = BUS_W;
    localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_CTRL = 3'd2,
                           A_INT  = 3'd3, A_DIV  = 3'd4;

    logic [6:0]       ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       txbuf_q, rxbuf_q;
    logic             txfull_q, rxfull_q;
    logic [1:0]       ovr_q;
    logic [3:0]       ist_q;

    logic wr, rd, div_ok, hs, tx_go, tx_ready, rx_got, txov_ev, rxov_ev, rx_store;
    logic [7:0]       rx_byte;
    logic [DIV_W-1:0] tx_len;
    logic [3:0]       ev;

    assign wr      = bus_valid & bus_write;
    assign rd      = bus_valid & ~bus_write;
    assign div_ok  = (div_q >= DIV_W'(MIN_DIV));
    assign hs      = ctrl_q[6];
    assign tx_len  = hs ? DIV_W'(1) : div_q;
    assign tx_go   = ctrl_q[0] & txfull_q & tx_ready & (div_ok | hs);
    assign txov_ev = wr & (bus_waddr == A_DATA) & txfull_q;
    assign rxov_ev = rx_got & rxfull_q;
    assign rx_store = rx_got & ~rxfull_q;
    assign ev      = {rxov_ev, txov_ev, rx_store, tx_go};

    sbu_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_go), .din(txbuf_q),
        .bit_len(tx_len), .ready(tx_ready), .txd(ser_tx)
    );

    sbu_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .arm(ctrl_q[1] & div_ok), .rxd(ser_rx),
        .bit_len(div_q), .got(rx_got), .dout(rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            div_q    <= '0;
            txbuf_q  <= '0;
            rxbuf_q  <= '0;
            txfull_q <= 1'b0;
            rxfull_q <= 1'b0;
            ovr_q    <= '0;
            ist_q    <= '0;
        end else begin
            if (wr && bus_waddr == A_CTRL) ctrl_q <= bus_wdata[6:0];
            if (wr && bus_waddr == A_DIV)  div_q  <= bus_wdata;
            if (tx_go) txfull_q <= 1'b0;
            else if (wr && bus_waddr == A_DATA && !txfull_q) begin
                txfull_q <= 1'b1;
                txbuf_q  <= bus_wdata[7:0];
            end
            if (rx_store) begin
                rxfull_q <= 1'b1;
                rxbuf_q  <= rx_byte;
            end else if (rd && bus_waddr == A_DATA) rxfull_q <= 1'b0;
            ovr_q <= (ovr_q & ~((wr && bus_waddr == A_STAT) ? bus_wdata[3:2] : 2'b00))
                     | {rxov_ev, txov_ev};
            ist_q <= (ist_q & ~((wr && bus_waddr == A_INT) ? bus_wdata[3:0] : 4'b0000))
                     | (ev & ctrl_q[5:2]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_waddr)
            A_DATA:  bus_rdata[7:0] = rxbuf_q;
            A_STAT:  bus_rdata[3:0] = {ovr_q, rxfull_q, txfull_q};
            A_CTRL:  bus_rdata[6:0] = ctrl_q;
            A_INT:   bus_rdata[3:0] = ist_q;
            A_DIV:   bus_rdata      = div_q;
            default: bus_rdata      = '0;
        endcase
        irq_tx = ist_q[0] | ist_q[2];
        irq_rx = ist_q[1] | ist_q[3];
    end

    // R6: a write into a full slot leaves it full with the old byte
    a_r6_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (txov_ev && !tx_go) |=> (txfull_q && $stable(txbuf_q)));
    // R6: transmit overrun flag is sticky until cleared
    a_r6_txov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q[0] && !(wr && bus_waddr == A_STAT && bus_wdata[2])) |=> ovr_q[0]);
    // R8: receive overrun keeps the held byte
    a_r8_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
        rxov_ev |=> $stable(rxbuf_q));
    // R9: transmit interrupt status is sticky until cleared
    a_r9_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ist_q[0] && !(wr && bus_waddr == A_INT && bus_wdata[0])) |=> ist_q[0]);
endmodule

// File: tb/sbuf_uart_bench.sv
module sbuf_uart_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        ser_rx = 1'b1, ser_tx, irq_tx, irq_rx;

    int total = 0, bad = 0, cycles = 0;
    logic [31:0] v;

    sbuf_uart u_sbuf_uart (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_rx(ser_rx), .ser_tx(ser_tx), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            total++; bad++;
            $display("FAIL watchdog expired: act=%0d exp<=%0d", cycles, WDOG_LIMIT);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_waddr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        bus_waddr = a;
        #1 d = bus_rdata;
    endtask

    // Line model: compares ser_tx with the expected 8N1 waveform every clock
    task automatic tx_frame(input logic [7:0] b, input int n, input int dly, input string req);
        int waited = 0;
        int errs = 0;
        int first_bad = -1;
        logic exp_bit;
        do begin
            @(negedge clk);
            waited++;
        end while (ser_tx !== 1'b0 && waited < 5000);
        if (dly >= 0) check({req, " load latency"}, waited, dly);
        for (int i = 1; i < 10 * n; i++) begin
            @(negedge clk);
            if (i / n == 0)      exp_bit = 1'b0;
            else if (i / n == 9) exp_bit = 1'b1;
            else                 exp_bit = b[i / n - 1];
            if (ser_tx !== exp_bit) begin
                errs++;
                if (first_bad < 0) first_bad = i;
            end
        end
        check({req, " frame line mismatches"}, errs, 0);
        if (errs != 0) $display("  first mismatch at bit cycle %0d of byte %0h", first_bad, b);
    endtask

    task automatic send(input logic [7:0] b, input int n);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ser_rx = fr[i];
            repeat (n - 1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            peek(3'(a), v);
            check("R1 register reset", v, 0);
        end
        check("R1 ser_tx idle", ser_tx, 1);
        check("R1 irqs low", {irq_tx, irq_rx}, 0);

        // R2 readback, R3 first frame, R9 transmit interrupt
        wr(3'd4, 32'd16);
        wr(3'd2, 32'h05);
        peek(3'd2, v); check("R2 control readback", v, 32'h05);
        peek(3'd4, v); check("R2 divider readback", v, 16);
        wr(3'd0, 32'hA5);
        tx_frame(8'hA5, 16, 1, "R3");
        peek(3'd1, v); check("R3 slot empty after load", v, 0);
        check("R9 irq_tx raised", irq_tx, 1);
        peek(3'd3, v); check("R9 tx int status", v, 32'h1);
        wr(3'd3, 32'h1);
        check("R9 irq_tx cleared", irq_tx, 0);

        // R4 invalid divider stalls transmit
        wr(3'd4, 32'd8);
        wr(3'd0, 32'h3C);
        begin
            int lows = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (ser_tx !== 1'b1) lows++;
            end
            check("R4 line held high with divider 8", lows, 0);
        end
        peek(3'd1, v); check("R4 slot still full", v, 32'h1);
        wr(3'd4, 32'd16);
        tx_frame(8'h3C, 16, -1, "R4 resumed");
        peek(3'd3, v); check("R9 tx int status again", v, 32'h1);
        wr(3'd3, 32'hF);

        // R5 fast test mode ignores divider
        wr(3'd4, 32'd8);
        wr(3'd2, 32'h41);
        wr(3'd0, 32'h96);
        tx_frame(8'h96, 1, 1, "R5");

        // R6 transmit overrun with transmit disabled
        wr(3'd4, 32'd16);
        wr(3'd2, 32'h10);
        wr(3'd0, 32'h11);
        wr(3'd0, 32'h22);
        peek(3'd1, v); check("R6 full plus overrun", v, 32'h5);
        peek(3'd3, v); check("R9 tx overrun int", v, 32'h4);
        check("R9 irq_tx on overrun", irq_tx, 1);
        check("R3 no send while disabled", ser_tx, 1);
        wr(3'd2, 32'h11);
        tx_frame(8'h11, 16, -1, "R6 kept first byte");
        peek(3'd1, v); check("R6 overrun sticky", v, 32'h4);
        wr(3'd1, 32'h4);
        peek(3'd1, v); check("R6 overrun cleared", v, 0);
        wr(3'd3, 32'h4);
        check("R9 irq_tx after clear", irq_tx, 0);

        // R7 receive
        wr(3'd2, 32'h0A);
        send(8'h5B, 16);
        peek(3'd1, v); check("R7 receive full", v, 32'h2);
        peek(3'd3, v); check("R9 rx int status", v, 32'h2);
        check("R9 irq_rx raised", irq_rx, 1);
        rd(3'd0, v); check("R7 received byte", v, 32'h5B);
        peek(3'd1, v); check("R7 read clears full", v, 0);
        wr(3'd3, 32'h2);

        // R8 receive overrun, interrupt enable gating for rx
        wr(3'd2, 32'h22);
        send(8'hC3, 16);
        send(8'h7E, 16);
        peek(3'd1, v); check("R8 full plus overrun", v, 32'hA);
        peek(3'd0, v); check("R8 held byte kept", v, 32'hC3);
        peek(3'd3, v); check("R9 only overrun int enabled", v, 32'h8);
        wr(3'd1, 32'h8);
        peek(3'd1, v); check("R8 overrun cleared", v, 32'h2);
        wr(3'd3, 32'hF);
        check("R9 irq_rx cleared", irq_rx, 0);

        // R7 disabled receiver, R4 invalid divider on receive
        rd(3'd0, v);
        wr(3'd2, 32'h00);
        send(8'h44, 16);
        peek(3'd1, v); check("R7 disabled receive ignored", v, 0);
        wr(3'd2, 32'h02);
        wr(3'd4, 32'd8);
        send(8'h44, 8);
        peek(3'd1, v); check("R4 receive blocked by divider", v, 0);

        summary();
    end
endmodule